// File: doc/BRIEF.md
# Bus Wait and Refresh Monitor

This block watches a processor bus without driving it. It samples a slow bus clock, an active-low address strobe, and two DRAM control lines (an active-low output-enable that doubles as the refresh line, and an active-low chip-enable). It timestamps everything in units of bus-clock rising edges.

Each address-strobe cycle is timed from the strobe's falling edge to its rising edge. A cycle held longer than the two-clock minimum is reported as a stretched cycle, together with the amount of stretch. A refresh is recognised as a falling output-enable while chip-enable is inactive, and is reported with its timestamp. Both kinds of report carry the distance to the previous report of the same kind.

All reports leave through one registered record qualified by a one-cycle valid pulse. A downstream logger or counter can consume the record directly.

Top module: `bus_wait_monitor`

## Requirements
- R1: The cycle count starts at 0 after reset and increases by exactly one for each rising edge seen on `busClk`. When a bus-clock rise and another edge are seen in the same sample, the other edge uses the count value from before the increment.
- R2: A falling edge of `busStrobeN` records the current cycle count as the start of a bus cycle.
- R3: On the rising edge of `busStrobeN`, the held length is the current count minus the recorded start. An event is produced only when the held length is greater than 2. In that event, `evtDelay` is the held length minus 2, saturated at 255.
- R4: A stretched-cycle event has `evtStamp` equal to its start count. `evtDelta` is its start count minus the start count of the previous stretched-cycle event. `evtDeltaValid` is 0 for the first such event after reset and 1 for every later one.
- R5: A refresh event occurs on a falling edge of `ramOeN` sampled while `ramCeN` is high. A falling edge of `ramOeN` while `ramCeN` is low produces no event.
- R6: A refresh event has `evtStamp` equal to the current count and `evtDelay` equal to 0. `evtDelta` is the count elapsed since the previous refresh. `evtDeltaValid` is 0 for the first refresh after reset and 1 for every later one.
- R7: Each event appears as a single-cycle `evtValid` pulse. `evtIsRefresh` is 1 for a refresh and 0 for a stretched cycle. Every event is delivered exactly once, in the order the events occur.
- R8: When both kinds of event are seen in the same sample, the refresh is output first. The stretched-cycle event follows in the next clock cycle.
- R9: Every input passes through a two-flop synchronizer. An input change driven before a `clk` edge shows up in `evtValid` just after the third `clk` rising edge.
- R10: During and straight after reset, `evtValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busClk | input | 1 | Monitored bus clock |
| busStrobeN | input | 1 | Monitored active-low address strobe |
| ramOeN | input | 1 | Monitored active-low DRAM output-enable / refresh line |
| ramCeN | input | 1 | Monitored active-low DRAM chip-enable |
| evtValid | output | 1 | One-cycle event qualifier |
| evtIsRefresh | output | 1 | 1 = refresh event, 0 = stretched-cycle event |
| evtStamp | output | 32 | Cycle count of the event |
| evtDelta | output | 32 | Distance to the previous event of the same kind |
| evtDeltaValid | output | 1 | evtDelta holds a real distance |
| evtDelay | output | 8 | Stretch in bus clocks (0 for refresh) |

## Verification
The embedded properties check on every cycle that:
- the cycle count never moves by more than one;
- the output selects are mutually exclusive;
- a refresh strobe always produces a refresh record on the next cycle;
- a coincident pair comes out refresh-then-delay on two consecutive cycles;
- every delay record carries a non-zero stretch;
- the first refresh carries no valid delta.

The values themselves can only be shown by the bench's scenarios:
- the exact stamps and deltas across many strobe lengths;
- the two-clock threshold and the saturation at 255;
- a refresh edge masked by an active chip-enable;
- the three-edge input latency.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
  localparam int IDX_BCLK = 0;
  localparam int IDX_STRB = 1;
  localparam int IDX_OE   = 2;
  localparam int IDX_CE   = 3;
  localparam int NUM_IN   = 4;

  typedef struct packed {
    logic cntInc;
    logic startCap;
    logic delayHit;
    logic refHit;
    logic emitRef;
    logic emitDelayNow;
    logic emitDelayHeld;
  } bmon_strobe_t;
endpackage

// File: rtl/bmon_sync.sv
module bmon_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] curOut,
  output logic [WIDTH-1:0] prevOut
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[s] <= RST_VAL;
          else       chain[s] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[s] <= RST_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevOut <= RST_VAL;
    else       prevOut <= chain[STAGES-1];
  end

  assign curOut = chain[STAGES-1];
endmodule

// File: rtl/bmon_ctrl.sv
module bmon_ctrl
  import bmon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] cur,
  input  logic [NUM_IN-1:0] prev,
  input  logic              longHeld,
  output bmon_strobe_t      strb
);
  logic pendDelay;
  logic clkRise, strbFall, strbRise, oeFall;
  logic unusedCePrev;

  assign clkRise  =  cur[IDX_BCLK] & ~prev[IDX_BCLK];
  assign strbFall = ~cur[IDX_STRB] &  prev[IDX_STRB];
  assign strbRise =  cur[IDX_STRB] & ~prev[IDX_STRB];
  assign oeFall   = ~cur[IDX_OE]   &  prev[IDX_OE];
  assign unusedCePrev = prev[IDX_CE];

  always_comb begin
    strb = '0;
    strb.cntInc        = clkRise;
    strb.startCap      = strbFall;
    strb.delayHit      = strbRise & longHeld;
    strb.refHit        = oeFall & cur[IDX_CE];
    strb.emitRef       = strb.refHit;
    strb.emitDelayNow  = strb.delayHit & ~strb.refHit;
    strb.emitDelayHeld = pendDelay;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendDelay <= 1'b0;
    else       pendDelay <= strb.delayHit & strb.refHit;
  end

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.emitRef, strb.emitDelayNow, strb.emitDelayHeld}));
endmodule

// File: rtl/bmon_dp.sv
module bmon_dp
  import bmon_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DLY_W = 8,
  parameter int MIN_HOLD = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  bmon_strobe_t     strb,
  output logic             longHeld,
  output logic             evtValid,
  output logic             evtIsRefresh,
  output logic [CNT_W-1:0] evtStamp,
  output logic [CNT_W-1:0] evtDelta,
  output logic             evtDeltaValid,
  output logic [DLY_W-1:0] evtDelay
);
  localparam logic [CNT_W-1:0] DLY_MAX = CNT_W'((1 << DLY_W) - 1);
  localparam logic [CNT_W-1:0] HOLD_MIN = CNT_W'(MIN_HOLD);

  logic [CNT_W-1:0] cycleCount, startCount, prevDlyStart, prevRefCount;
  logic             hasPrevDly, hasPrevRef;
  logic [CNT_W-1:0] heldLen, excess;
  logic [DLY_W-1:0] delayVal;
  logic [CNT_W-1:0] holdStamp, holdDelta;
  logic             holdDeltaValid;
  logic [DLY_W-1:0] holdDelay;

  assign heldLen  = cycleCount - startCount;
  assign longHeld = heldLen > HOLD_MIN;
  assign excess   = heldLen - HOLD_MIN;
  assign delayVal = (excess > DLY_MAX) ? DLY_MAX[DLY_W-1:0] : excess[DLY_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCount   <= '0;
      startCount   <= '0;
      prevDlyStart <= '0;
      prevRefCount <= '0;
      hasPrevDly   <= 1'b0;
      hasPrevRef   <= 1'b0;
    end else begin
      if (strb.cntInc)   cycleCount <= cycleCount + 1'b1;
      if (strb.startCap) startCount <= cycleCount;
      if (strb.delayHit) begin
        prevDlyStart <= startCount;
        hasPrevDly   <= 1'b1;
      end
      if (strb.refHit) begin
        prevRefCount <= cycleCount;
        hasPrevRef   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdStamp      <= '0;
      holdDelta      <= '0;
      holdDeltaValid <= 1'b0;
      holdDelay      <= '0;
    end else if (strb.delayHit) begin
      holdStamp      <= startCount;
      holdDelta      <= startCount - prevDlyStart;
      holdDeltaValid <= hasPrevDly;
      holdDelay      <= delayVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtValid      <= 1'b0;
      evtIsRefresh  <= 1'b0;
      evtStamp      <= '0;
      evtDelta      <= '0;
      evtDeltaValid <= 1'b0;
      evtDelay      <= '0;
    end else begin
      evtValid <= strb.emitRef | strb.emitDelayNow | strb.emitDelayHeld;
      if (strb.emitRef) begin
        evtIsRefresh  <= 1'b1;
        evtStamp      <= cycleCount;
        evtDelta      <= cycleCount - prevRefCount;
        evtDeltaValid <= hasPrevRef;
        evtDelay      <= '0;
      end else if (strb.emitDelayNow) begin
        evtIsRefresh  <= 1'b0;
        evtStamp      <= startCount;
        evtDelta      <= startCount - prevDlyStart;
        evtDeltaValid <= hasPrevDly;
        evtDelay      <= delayVal;
      end else if (strb.emitDelayHeld) begin
        evtIsRefresh  <= 1'b0;
        evtStamp      <= holdStamp;
        evtDelta      <= holdDelta;
        evtDeltaValid <= holdDeltaValid;
        evtDelay      <= holdDelay;
      end
    end
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleCount == $past(cycleCount)) || (cycleCount == $past(cycleCount) + 1'b1));

  // R3
  delay_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtIsRefresh) |-> (evtDelay != '0));

  // R7
  ref_record_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitRef |=> (evtValid && evtIsRefresh));

  // R8
  ref_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.refHit && strb.delayHit) |=> ##1 (evtValid && !evtIsRefresh));

  // R6
  first_ref_delta_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.refHit && !hasPrevRef) |=> (evtValid && !evtDeltaValid));
endmodule

// File: rtl/bus_wait_monitor.sv
module bus_wait_monitor
  import bmon_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DLY_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HOLD = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busClk,
  input  logic             busStrobeN,
  input  logic             ramOeN,
  input  logic             ramCeN,
  output logic             evtValid,
  output logic             evtIsRefresh,
  output logic [CNT_W-1:0] evtStamp,
  output logic [CNT_W-1:0] evtDelta,
  output logic             evtDeltaValid,
  output logic [DLY_W-1:0] evtDelay
);
  localparam logic [NUM_IN-1:0] IDLE_LEVELS = NUM_IN'(4'b1110);

  logic [NUM_IN-1:0] rawIn, curS, prevS;
  bmon_strobe_t      strb;
  logic              longHeld;

  assign rawIn = {ramCeN, ramOeN, busStrobeN, busClk};

  bmon_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVELS)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .curOut(curS), .prevOut(prevS)
  );

  bmon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cur(curS), .prev(prevS), .longHeld(longHeld), .strb(strb)
  );

  bmon_dp #(.CNT_W(CNT_W), .DLY_W(DLY_W), .MIN_HOLD(MIN_HOLD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .longHeld(longHeld),
    .evtValid(evtValid), .evtIsRefresh(evtIsRefresh), .evtStamp(evtStamp),
    .evtDelta(evtDelta), .evtDeltaValid(evtDeltaValid), .evtDelay(evtDelay)
  );
endmodule

// File: tb/tb_bus_wait_monitor.sv
`timescale 1ns/1ps
module tb_bus_wait_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busClk = 1'b0, busStrobeN = 1'b1, ramOeN = 1'b1, ramCeN = 1'b1;
  logic evtValid, evtIsRefresh, evtDeltaValid;
  logic [31:0] evtStamp, evtDelta;
  logic [7:0] evtDelay;

  always #10 clk = ~clk;

  bus_wait_monitor dut (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busStrobeN(busStrobeN),
    .ramOeN(ramOeN), .ramCeN(ramCeN), .evtValid(evtValid), .evtIsRefresh(evtIsRefresh),
    .evtStamp(evtStamp), .evtDelta(evtDelta), .evtDeltaValid(evtDeltaValid), .evtDelay(evtDelay)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  localparam int QD = 8192;
  logic        qRef [QD];
  logic [31:0] qStamp [QD];
  logic [31:0] qDelta [QD];
  logic        qDv [QD];
  logic [7:0]  qDly [QD];
  int wrIdx = 0, rdIdx = 0;

  logic [31:0] mCount = 0, mStart = 0, mPrevDStart = 0, mPrevRef = 0;
  bit mHasD = 0, mHasR = 0;

  function automatic logic [7:0] satDelay(input logic [31:0] held);
    return (held - 32'd2 > 32'd255) ? 8'd255 : 8'(held - 32'd2);
  endfunction

  task automatic push(input logic r, input logic [31:0] s, input logic [31:0] d,
                      input logic dv, input logic [7:0] dl);
    qRef[wrIdx] = r; qStamp[wrIdx] = s; qDelta[wrIdx] = d; qDv[wrIdx] = dv; qDly[wrIdx] = dl;
    wrIdx++;
  endtask

  // drive one sample step and update the reference model
  task automatic step(input logic nClk, input logic nStrb, input logic nOe, input logic nCe);
    logic [31:0] held;
    bit dHit, rHit;
    @(negedge clk);
    dHit = 0; rHit = 0;
    // R5: refresh only when output-enable falls and chip-enable is high
    if (ramOeN && !nOe && nCe) rHit = 1;
    held = mCount - mStart;
    // R3: strobe rise reports only holds longer than 2
    if (!busStrobeN && nStrb && held > 32'd2) dHit = 1;
    // R8: refresh ahead of a coincident delay
    if (rHit) begin
      // R6
      push(1'b1, mCount, mCount - mPrevRef, mHasR, 8'd0);
      mPrevRef = mCount; mHasR = 1;
    end
    if (dHit) begin
      // R4
      push(1'b0, mStart, mStart - mPrevDStart, mHasD, satDelay(held));
      mPrevDStart = mStart; mHasD = 1;
    end
    // R2
    if (busStrobeN && !nStrb) mStart = mCount;
    // R1
    if (!busClk && nClk) mCount = mCount + 1;
    busClk = nClk; busStrobeN = nStrb; ramOeN = nOe; ramCeN = nCe;
  endtask

  task automatic expect1(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s %s", req, msg); end
  endtask

  // R7: stream comparison of every output record
  always @(negedge clk) begin
    if (rstN && evtValid && !finished) begin
      checks++;
      if (rdIdx >= wrIdx) begin
        fails++;
        $display("FAIL R7 unexpected event actual ref=%0b stamp=%0d expected none", evtIsRefresh, evtStamp);
      end else begin
        if (evtIsRefresh !== qRef[rdIdx] || evtStamp !== qStamp[rdIdx] || evtDelay !== qDly[rdIdx]
            || evtDeltaValid !== qDv[rdIdx] || (qDv[rdIdx] && evtDelta !== qDelta[rdIdx])) begin
          fails++;
          $display("FAIL %s actual ref=%0b stamp=%0d delta=%0d dv=%0b dly=%0d expected ref=%0b stamp=%0d delta=%0d dv=%0b dly=%0d",
                   qRef[rdIdx] ? "R6" : "R4", evtIsRefresh, evtStamp, evtDelta, evtDeltaValid, evtDelay,
                   qRef[rdIdx], qStamp[rdIdx], qDelta[rdIdx], qDv[rdIdx], qDly[rdIdx]);
        end
        rdIdx++;
      end
    end
  end

  task automatic clkPulses(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, busStrobeN, ramOeN, ramCeN);
      step(1'b0, busStrobeN, ramOeN, ramCeN);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual running expected done");
      finish_run();
    end
  end

  initial begin
    int sawEvt;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    // R10
    expect1(evtValid === 1'b0, "R10", $sformatf("in reset actual valid=%0b expected 0", evtValid));
    rstN = 1'b1;
    @(negedge clk);
    expect1(evtValid === 1'b0, "R10", $sformatf("after reset actual valid=%0b expected 0", evtValid));

    clkPulses(3);
    // R9: latency of a refresh edge
    step(busClk, busStrobeN, 1'b0, 1'b1);
    @(negedge clk); @(negedge clk);
    expect1(evtValid === 1'b0, "R9", $sformatf("two edges actual valid=%0b expected 0", evtValid));
    @(negedge clk);
    expect1(evtValid === 1'b1 && evtIsRefresh === 1'b1, "R9",
            $sformatf("third edge actual valid=%0b ref=%0b expected 1 1", evtValid, evtIsRefresh));
    step(busClk, busStrobeN, 1'b1, 1'b1);

    // R5: masked refresh edge
    step(busClk, busStrobeN, ramOeN, 1'b0);
    step(busClk, busStrobeN, 1'b0, 1'b0);
    sawEvt = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (evtValid) sawEvt++; end
    expect1(sawEvt == 0, "R5", $sformatf("chip-enable low actual events=%0d expected 0", sawEvt));
    step(busClk, busStrobeN, 1'b1, 1'b1);

    // R3: exactly 2 clocks held, then 3
    step(busClk, 1'b0, ramOeN, ramCeN);
    clkPulses(2);
    step(busClk, 1'b1, ramOeN, ramCeN);
    sawEvt = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (evtValid) sawEvt++; end
    expect1(sawEvt == 0, "R3", $sformatf("held 2 actual events=%0d expected 0", sawEvt));
    step(busClk, 1'b0, ramOeN, ramCeN);
    clkPulses(3);
    step(busClk, 1'b1, ramOeN, ramCeN);
    @(negedge clk); @(negedge clk); @(negedge clk);
    expect1(evtValid && !evtIsRefresh && evtDelay == 8'd1, "R3",
            $sformatf("held 3 actual valid=%0b dly=%0d expected 1 1", evtValid, evtDelay));

    // R3: saturation
    step(busClk, 1'b0, ramOeN, ramCeN);
    clkPulses(300);
    step(busClk, 1'b1, ramOeN, ramCeN);
    @(negedge clk); @(negedge clk); @(negedge clk);
    expect1(evtValid && evtDelay == 8'd255, "R3",
            $sformatf("saturate actual dly=%0d expected 255", evtDelay));

    // R8: coincident refresh and delay
    step(busClk, 1'b0, ramOeN, ramCeN);
    clkPulses(5);
    step(busClk, 1'b1, 1'b0, 1'b1);
    @(negedge clk); @(negedge clk); @(negedge clk);
    expect1(evtValid && evtIsRefresh, "R8",
            $sformatf("first actual valid=%0b ref=%0b expected 1 1", evtValid, evtIsRefresh));
    @(negedge clk);
    expect1(evtValid && !evtIsRefresh && evtDelay == 8'd3, "R8",
            $sformatf("second actual valid=%0b ref=%0b dly=%0d expected 1 0 3", evtValid, evtIsRefresh, evtDelay));
    step(busClk, busStrobeN, 1'b1, 1'b1);

    // random traffic, R1 R2 R4 R6 covered by the stream comparison
    for (int i = 0; i < 4000; i++) begin
      logic nc, ns, no, ne;
      nc = ($urandom % 2) ? ~busClk : busClk;
      ns = ($urandom % 7 == 0) ? ~busStrobeN : busStrobeN;
      no = ($urandom % 6 == 0) ? ~ramOeN : ramOeN;
      ne = ($urandom % 9 == 0) ? ~ramCeN : ramCeN;
      step(nc, ns, no, ne);
    end
    repeat (10) @(negedge clk);
    // R7
    expect1(rdIdx == wrIdx, "R7", $sformatf("delivered actual=%0d expected=%0d", rdIdx, wrIdx));
    finish_run();
  end
endmodule